// File: doc/BRIEF.md
# Segment Lookaside Buffer

This block is a small, fully associative table of segment descriptors. It sits in front of a page-table walker. Each entry pairs two 64-bit words. The segment-tag word holds the upper bits of an effective address together with a valid flag. The descriptor word holds a two-bit segment-size field, and the key, no-execute and large-page attributes pass through it unchanged. A combinational lookup port takes an effective address. In the same cycle it returns whether an entry covers that address, which entry it is, and that entry's descriptor word. Hash-table walking and protection checks are left to the logic downstream.

A single command port changes or inspects the table. The commands are: write one slot (the write is checked before it is accepted), read back either word of one slot, invalidate every entry except entry 0, and invalidate the entry that covers a given address. A command is accepted on any cycle in which `op_valid` is high. The port never applies back-pressure, so there is no ready signal. Exactly one response cycle follows each recognised command. It carries an error flag for rejected commands, the read data, and a one-cycle TLB-flush request whenever an invalidation actually cleared a valid entry.

Top module: `slb_unit`

## Requirements
- R1: After reset every entry is invalid: lookups miss (`lk_hit`=0, `lk_vsid`=0), and `rsp_valid`, `rsp_err` and `tlb_flush` are low.
- R2: A lookup hits an entry whose descriptor size field (bits 63:62) is 00 (256 MB) when its tag word equals `lk_addr[63:28]` in bits 63:28, bit 27 set (valid), and bits 26:0 zero. On a hit, `lk_vsid` returns the stored descriptor word and `lk_idx` returns the entry index in the same cycle. On a miss both are zero.
- R3: An entry whose size field is 01 (1 TB) hits when its tag word equals `lk_addr[63:40]` in bits 63:40, bits 39:28 zero, bit 27 set, and bits 26:0 zero.
- R4: When several entries hit, the lowest-indexed one is reported, for lookups and for invalidate-by-address alike.
- R5: A write (`op_code`=1) takes its slot from `op_addr[11:0]`. It is rejected with `rsp_err`=1 and leaves the table unchanged when that value is at or above the entry count.
- R6: A write is rejected when `op_data[63:62]` is 10 or 11, or when it is 01 while `cfg_1t_en` is low.
- R7: An accepted write stores `op_addr` with bits 26:0 cleared as the tag word, keeping bits 63:28 and the valid bit 27. It stores `op_data` unchanged as the descriptor word.
- R8: Reading the tag word (`op_code`=2) or the descriptor word (`op_code`=3) of slot `op_addr[11:0]` returns it on `rsp_data`. A slot at or above the entry count gives `rsp_err`=1 and `rsp_data`=0.
- R9: Invalidate-all (`op_code`=4) clears the valid bit of every entry except entry 0. It raises `tlb_flush` only if at least one cleared entry was valid.
- R10: Invalidate-by-address (`op_code`=5) clears the valid bit of the lowest entry covering `op_addr` and raises `tlb_flush`. On a miss nothing changes and neither the flush nor the error flag rises.
- R11: Every recognised command gives `rsp_valid` for exactly one cycle, the cycle after acceptance. The codes 0, 6 and 7 are ignored, with no response and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_1t_en | input | 1 | Allows writes of 1 TB segment entries |
| lk_addr | input | 64 | Effective address to translate |
| lk_hit | output | 1 | An entry covers `lk_addr` |
| lk_idx | output | $clog2(N_ENTRIES) | Index of the winning entry |
| lk_vsid | output | 64 | Descriptor word of the winning entry |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | Command code: 1 write, 2 read tag, 3 read descriptor, 4 invalidate all, 5 invalidate by address |
| op_addr | input | 64 | Tag/slot operand or address operand |
| op_data | input | 64 | Descriptor word for writes |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Command rejected |
| rsp_data | output | 64 | Read data |
| tlb_flush | output | 1 | Full TLB flush request |

## Verification
Some properties are checked on every cycle: a response appears only after a recognised command, a flush appears only after an invalidation and never with an error, bad size encodings and disabled 1 TB writes are always rejected, out-of-range reads always fail, and a hitting descriptor never carries a bad size code. Other behaviour only shows up in the bench's command and lookup sequences, because it depends on the table's history. This covers the choice between the two segment masks, the lowest-index priority among overlapping entries, entry 0 surviving invalidate-all, and the exact bits kept by a write.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned SLOT_FLD_W = 12;
  localparam int unsigned VALID_BIT  = 27;
  localparam int unsigned SEG256_LSB = 28;
  localparam int unsigned SEG1T_LSB  = 40;
  localparam int unsigned SIZE_LSB   = 62;

  // Tag bits kept by a write: segment bits plus valid flag.
  localparam logic [WORD_W-1:0] TAG_KEEP = {{(WORD_W-VALID_BIT){1'b1}}, {VALID_BIT{1'b0}}};

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_RD_TAG   = 3'd2,
    OP_RD_DESC  = 3'd3,
    OP_INV_ALL  = 3'd4,
    OP_INV_ADDR = 3'd5
  } slb_op_e;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_1T   = 2'b01
  } seg_size_e;
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64
) (
  input  logic [N_ENTRIES-1:0][WORD_W-1:0] tag_q,
  input  logic [N_ENTRIES-1:0][WORD_W-1:0] desc_q,
  input  logic [WORD_W-1:0]                addr,
  output logic [N_ENTRIES-1:0]             hit_vec
);
  logic [WORD_W-1:0] key_256m;
  logic [WORD_W-1:0] key_1t;

  assign key_256m = {addr[WORD_W-1:SEG256_LSB], 1'b1, {VALID_BIT{1'b0}}};
  assign key_1t   = {addr[WORD_W-1:SEG1T_LSB], {(SEG1T_LSB-SEG256_LSB){1'b0}},
                     1'b1, {VALID_BIT{1'b0}}};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [1:0] sz;
    assign sz = desc_q[g][SIZE_LSB+1:SIZE_LSB];
    assign hit_vec[g] = ((tag_q[g] == key_256m) && (sz == SZ_256M)) ||
                        ((tag_q[g] == key_1t)   && (sz == SZ_1T));
  end
endmodule

// File: rtl/slb_prio.sv
module slb_prio #(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] req,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slb_store_chk.sv
module slb_store_chk
  import slb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [WORD_W-1:0] op_addr,
  input  logic [WORD_W-1:0] op_data,
  input  logic              cfg_1t_en,
  output logic              slot_ok,
  output logic              size_ok,
  output logic [IDX_W-1:0]  slot
);
  logic [SLOT_FLD_W-1:0] slot_fld;
  logic [1:0]            sz;

  assign slot_fld = op_addr[SLOT_FLD_W-1:0];
  assign slot     = slot_fld[IDX_W-1:0];
  assign slot_ok  = 32'(slot_fld) < 32'(N_ENTRIES);
  assign sz       = op_data[SIZE_LSB+1:SIZE_LSB];
  assign size_ok  = (sz == SZ_256M) || ((sz == SZ_1T) && cfg_1t_en);
endmodule

// File: rtl/slb_unit.sv
module slb_unit
  import slb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_1t_en,
  input  logic [63:0]       lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [63:0]       lk_vsid,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [63:0]       op_addr,
  input  logic [63:0]       op_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_data,
  output logic              tlb_flush
);
  logic [N_ENTRIES-1:0][WORD_W-1:0] tag_q, tag_d;
  logic [N_ENTRIES-1:0][WORD_W-1:0] desc_q, desc_d;

  logic [N_ENTRIES-1:0] lk_vec, inv_vec;
  logic                 inv_found;
  logic [IDX_W-1:0]     inv_idx;
  logic                 slot_ok, size_ok;
  logic [IDX_W-1:0]     slot;

  logic              rsp_valid_d, rsp_err_d, flush_d;
  logic [WORD_W-1:0] rsp_data_d;

  // Lookup path
  slb_match #(.N_ENTRIES(N_ENTRIES)) u_lk_match (
    .tag_q(tag_q), .desc_q(desc_q), .addr(lk_addr), .hit_vec(lk_vec)
  );
  slb_prio #(.N_ENTRIES(N_ENTRIES)) u_lk_prio (
    .req(lk_vec), .found(lk_hit), .idx(lk_idx)
  );
  assign lk_vsid = lk_hit ? desc_q[lk_idx] : '0;

  // Invalidate-by-address path
  slb_match #(.N_ENTRIES(N_ENTRIES)) u_inv_match (
    .tag_q(tag_q), .desc_q(desc_q), .addr(op_addr), .hit_vec(inv_vec)
  );
  slb_prio #(.N_ENTRIES(N_ENTRIES)) u_inv_prio (
    .req(inv_vec), .found(inv_found), .idx(inv_idx)
  );

  slb_store_chk #(.N_ENTRIES(N_ENTRIES)) u_chk_store (
    .op_addr(op_addr), .op_data(op_data), .cfg_1t_en(cfg_1t_en),
    .slot_ok(slot_ok), .size_ok(size_ok), .slot(slot)
  );

  always_comb begin
    tag_d       = tag_q;
    desc_d      = desc_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    flush_d     = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_WRITE: begin
          rsp_valid_d = 1'b1;
          if (slot_ok && size_ok) begin
            tag_d[slot]  = op_addr & TAG_KEEP;
            desc_d[slot] = op_data;
          end else begin
            rsp_err_d = 1'b1;
          end
        end
        OP_RD_TAG, OP_RD_DESC: begin
          rsp_valid_d = 1'b1;
          if (slot_ok) begin
            rsp_data_d = (op_code == OP_RD_TAG) ? tag_q[slot] : desc_q[slot];
          end else begin
            rsp_err_d = 1'b1;
          end
        end
        OP_INV_ALL: begin
          rsp_valid_d = 1'b1;
          for (int i = 1; i < N_ENTRIES; i++) begin
            if (tag_q[i][VALID_BIT]) begin
              tag_d[i][VALID_BIT] = 1'b0;
              flush_d             = 1'b1;
            end
          end
        end
        OP_INV_ADDR: begin
          rsp_valid_d = 1'b1;
          if (inv_found) begin
            tag_d[inv_idx][VALID_BIT] = 1'b0;
            flush_d                   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= '0;
      desc_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      tlb_flush <= 1'b0;
    end else begin
      tag_q     <= tag_d;
      desc_q    <= desc_d;
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_data  <= rsp_data_d;
      tlb_flush <= flush_d;
    end
  end
endmodule

// File: rtl/slb_unit_chk.sv
module slb_unit_chk #(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_1t_en,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [63:0]      lk_vsid,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [63:0]      op_addr,
  input logic [63:0]      op_data,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [63:0]      rsp_data,
  input logic             tlb_flush
);
  logic known_op, inv_op, rd_op;
  assign known_op = (op_code >= 3'd1) && (op_code <= 3'd5);
  assign inv_op   = (op_code == 3'd4) || (op_code == 3'd5);
  assign rd_op    = (op_code == 3'd2) || (op_code == 3'd3);

  AST_RSP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known_op) |=> rsp_valid);                                  // R11
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && known_op) |=> !rsp_valid);                                // R11
  AST_FLUSH_ONLY_INV: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && inv_op) |=> !tlb_flush);                                  // R9
  AST_FLUSH_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> (rsp_valid && !rsp_err));                                 // R10
  AST_BAD_SIZE_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && op_data[63]) |=> rsp_err);              // R6
  AST_1T_DIS_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && op_data[63:62] == 2'b01 && !cfg_1t_en)
      |=> rsp_err);                                                         // R6
  AST_OOR_SLOT_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (rd_op || op_code == 3'd1) && 32'(op_addr[11:0]) >= 32'(N_ENTRIES))
      |=> (rsp_err && rsp_data == 64'd0));                                  // R5
  AST_HIT_GOOD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_vsid[63]);                                               // R2
endmodule

bind slb_unit slb_unit_chk #(.N_ENTRIES(N_ENTRIES)) u_slb_unit_chk (
  .clk(clk), .rst_n(rst_n), .cfg_1t_en(cfg_1t_en),
  .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
  .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .tlb_flush(tlb_flush)
);

// File: tb/slb_unit_bench.sv
`timescale 1ns/1ps
module slb_unit_bench;
  localparam int N = 64;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_1t_en;
  logic [63:0] lk_addr;
  logic lk_hit;
  logic [IW-1:0] lk_idx;
  logic [63:0] lk_vsid;
  logic op_valid;
  logic [2:0] op_code;
  logic [63:0] op_addr, op_data;
  logic rsp_valid, rsp_err, tlb_flush;
  logic [63:0] rsp_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_tag [N];
  logic [63:0] m_desc[N];

  always #10 clk = ~clk;

  slb_unit #(.N_ENTRIES(N)) u_slb_unit (
    .clk(clk), .rst_n(rst_n), .cfg_1t_en(cfg_1t_en),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .tlb_flush(tlb_flush)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_covers(input int i, input logic [63:0] a);
    logic [63:0] k256, k1t;
    k256 = {a[63:28], 1'b1, 27'd0};
    k1t  = {a[63:40], 12'd0, 1'b1, 27'd0};
    return (m_tag[i] == k256 && m_desc[i][63:62] == 2'b00) ||
           (m_tag[i] == k1t  && m_desc[i][63:62] == 2'b01);
  endfunction

  function automatic int m_find(input logic [63:0] a);
    for (int i = 0; i < N; i++) if (m_covers(i, a)) return i;
    return -1;
  endfunction

  function automatic int m_count(input logic [63:0] a);
    int c = 0;
    for (int i = 0; i < N; i++) if (m_covers(i, a)) c++;
    return c;
  endfunction

  task automatic chk_lookup(input logic [63:0] a);
    int e, c;
    string t;
    e = m_find(a);
    c = m_count(a);
    lk_addr = a;
    #2;
    if (c > 1) t = "R4 priority";
    else if (e >= 0 && m_desc[e][63:62] == 2'b01) t = "R3 1TB lookup";
    else t = "R2 lookup";
    chk({t, " hit"}, {63'd0, lk_hit}, {63'd0, e >= 0});
    chk({t, " idx"}, 64'(lk_idx), (e >= 0) ? 64'(e) : 64'd0);
    chk({t, " vsid"}, lk_vsid, (e >= 0) ? m_desc[e] : 64'd0);
  endtask

  task automatic do_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d);
    int slot, e;
    bit sok, szok, ev, eerr, efl;
    logic [63:0] edata;
    string t;
    slot = int'(a[11:0]);
    sok = slot < N;
    ev = 1; eerr = 0; efl = 0; edata = '0; t = "R11";
    case (op)
      3'd1: begin
        szok = (d[63:62] == 2'b00) || (d[63:62] == 2'b01 && cfg_1t_en);
        t = !sok ? "R5 write slot" : (!szok ? "R6 write size" : "R7 write");
        eerr = !(sok && szok);
      end
      3'd2, 3'd3: begin
        t = "R8 read";
        if (sok) edata = (op == 3'd2) ? m_tag[slot] : m_desc[slot];
        else eerr = 1;
      end
      3'd4: begin
        t = "R9 inv all";
        for (int i = 1; i < N; i++) if (m_tag[i][27]) efl = 1;
      end
      3'd5: begin
        t = "R10 inv addr";
        efl = m_find(a) >= 0;
      end
      default: ev = 0;
    endcase
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_addr = a; op_data = d;
    @(negedge clk);
    op_valid = 1'b0;
    chk({t, " rsp_valid"}, {63'd0, rsp_valid}, {63'd0, ev});
    chk({t, " rsp_err"}, {63'd0, rsp_err}, {63'd0, eerr});
    chk({t, " rsp_data"}, rsp_data, edata);
    chk({t, " tlb_flush"}, {63'd0, tlb_flush}, {63'd0, efl});
    case (op)
      3'd1: if (!eerr) begin
        m_tag[slot]  = a & {37'h1F_FFFF_FFFF, 27'd0};
        m_desc[slot] = d;
      end
      3'd4: for (int i = 1; i < N; i++) m_tag[i][27] = 1'b0;
      3'd5: begin
        e = m_find(a);
        if (e >= 0) m_tag[e][27] = 1'b0;
      end
      default: ;
    endcase
  endtask

  function automatic logic [35:0] seg(input int k);
    logic [23:0] hi;
    logic [11:0] lo;
    hi = 24'h8A0000 | 24'(k % 4);
    lo = (k < 4) ? 12'd0 : 12'(k);
    return {hi, lo};
  endfunction

  function automatic logic [63:0] rnd_lk_addr();
    if ($urandom % 8 == 0) return {$urandom, $urandom};
    return {seg($urandom % 8), 28'($urandom)};
  endfunction

  function automatic logic [63:0] rnd_wr_addr();
    logic [11:0] s;
    logic v;
    s = ($urandom % 10 == 0) ? 12'($urandom) : 12'($urandom % N);
    v = ($urandom % 8 != 0);
    return {seg($urandom % 8), v, 15'($urandom), s};
  endfunction

  function automatic logic [63:0] rnd_desc();
    int r;
    logic [1:0] sz;
    r = $urandom % 10;
    sz = (r < 5) ? 2'b00 : (r < 9) ? 2'b01 : 2'(2 + $urandom % 2);
    return {sz, 30'($urandom), 32'($urandom)};
  endfunction

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_desc[i] = '0; end
    rst_n = 0; cfg_1t_en = 1; lk_addr = '0;
    op_valid = 0; op_code = '0; op_addr = '0; op_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 rsp_err", {63'd0, rsp_err}, 64'd0);
    chk("R1 tlb_flush", {63'd0, tlb_flush}, 64'd0);
    for (int k = 0; k < 8; k++) chk_lookup({seg(k), 28'h0});
    do_op(3'd2, 64'd0, 64'd0);   // R1 entry 0 tag reads zero

    // R2/R3/R4 directed: 256 MB entry at slot 9, 1 TB entry at slot 3 same segment
    do_op(3'd1, {seg(0), 1'b1, 15'h7ABC, 12'd9}, 64'h0000_0000_0000_0F00); // R7
    do_op(3'd2, 64'd9, 64'd0);
    do_op(3'd1, {seg(0), 1'b1, 15'h0, 12'd3}, 64'h4000_0000_0000_0A00);
    chk_lookup({seg(0), 28'h123_4567});               // R4 slot 3 wins
    chk_lookup({seg(0) + 36'd5, 28'h0});              // R3 covered by 1 TB only
    do_op(3'd5, {seg(0), 28'h0}, 64'd0);              // R10 clears slot 3
    chk_lookup({seg(0), 28'h0});                      // now slot 9
    do_op(3'd5, {seg(7), 28'h0}, 64'd0);              // R10 miss

    // R5 slot range, R6 sizes
    do_op(3'd1, {seg(1), 1'b1, 15'h0, 12'd64}, 64'd0);
    do_op(3'd1, {seg(1), 1'b1, 15'h0, 12'hFFF}, 64'd0);
    do_op(3'd1, {seg(1), 1'b1, 15'h0, 12'd4}, 64'h8000_0000_0000_0000);
    do_op(3'd1, {seg(1), 1'b1, 15'h0, 12'd4}, 64'hC000_0000_0000_0000);
    cfg_1t_en = 0;
    do_op(3'd1, {seg(1), 1'b1, 15'h0, 12'd4}, 64'h4000_0000_0000_0000);
    cfg_1t_en = 1;
    do_op(3'd3, 64'd4, 64'd0);                        // unchanged by rejects
    do_op(3'd3, 64'd64, 64'd0);                       // R8 out of range
    do_op(3'd2, 64'hFFF, 64'd0);

    // R9 entry 0 survives
    do_op(3'd1, {seg(2), 1'b1, 15'h0, 12'd0}, 64'd0);
    do_op(3'd1, {seg(3), 1'b1, 15'h0, 12'd5}, 64'd0);
    do_op(3'd4, 64'd0, 64'd0);
    do_op(3'd2, 64'd0, 64'd0);
    do_op(3'd2, 64'd5, 64'd0);
    chk_lookup({seg(2), 28'h0});
    do_op(3'd4, 64'd0, 64'd0);                        // nothing left: no flush

    // R11 unused codes ignored
    do_op(3'd0, {seg(2), 28'h0}, 64'd0);
    do_op(3'd6, {seg(2), 28'h0}, 64'd0);
    do_op(3'd7, 64'd0, 64'd0);
    chk_lookup({seg(2), 28'h0});

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 2) cfg_1t_en = ~cfg_1t_en;
      if (r < 50) do_op(3'd1, rnd_wr_addr(), rnd_desc());
      else if (r < 65) do_op(3'(2 + $urandom % 2), 64'($urandom % 80), 64'd0);
      else if (r < 85) do_op(3'd5, rnd_lk_addr(), 64'd0);
      else if (r < 87) do_op(3'd4, 64'd0, 64'd0);
      else do_op(3'(($urandom % 2) ? 0 : 6 + $urandom % 2), rnd_lk_addr(), 64'd0);
      chk_lookup(rnd_lk_addr());
      chk_lookup(rnd_lk_addr());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule